// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Detector

This block turns a set of already filtered input pin levels into interrupt status, wake status and a pending flag for each pin. Every pin has its own control word. The control word selects edge or level triggering and the active polarity, including both-edges in edge mode. It holds an interrupt enable, a separate unmask bit and three wake enables, one for each of three sleep states. A pin reports pending when either of its status bits is set and the pin is unmasked. A single registered interrupt line is the OR of all pending flags.

Software reaches the control words through a simple write port and a read port. A write loads the configuration fields and clears status bits through write-one-to-clear bits. A read returns one cycle later a packed view of the control word, both status bits, the current pin level and the pending flag. Because the status bits sit at the same positions in both directions, writing back a word that was just read clears every status bit it showed and leaves the configuration as it was.

Top module: `pin_irq_detect`

## Requirements
- R1: After a synchronous reset, every control word, status bit, pending flag, `irq_o` and `rd_vld_o` is 0.
- R2: In edge mode (control bit 0 = 0), polarity code 00 on bits [2:1] sets interrupt status on a rising edge, 01 sets it on a falling edge and 10 sets it on either edge. Status appears in the read view two clock edges after the pin input changes.
- R3: In level mode (control bit 0 = 1), code 00 sets status while the pin is high and 01 sets it while the pin is low. A clear written while the pin is still at the active level leaves status set. Once the pin has left the active level, status stays set until it is cleared.
- R4: Codes 10 and 11 in level mode, and code 11 in edge mode, never set any status.
- R5: With interrupt enable (bit 3) at 0, a trigger sets no interrupt status. Setting the enable later does not set status for a trigger that came earlier.
- R6: Edge-mode interrupt status holds once set. Further edges are merged, and one clear removes it.
- R7: A write with bit 8 = 1 clears interrupt status and a write with bit 9 = 1 clears wake status. Writing 0 there leaves status unchanged. Writing back a just-read word clears all status it showed and keeps the configuration bits [7:0].
- R8: The pending flag equals (interrupt status OR wake status) AND unmask (bit 4). It changes in the same cycle as the status or the unmask write. `irq_o` is the OR of all pending flags, one cycle later.
- R9: Wake status is set by a trigger when `sleep_state_i` is 1, 2 or 3 and wake-enable bit 5, 6 or 7 respectively is 1, independently of the interrupt enable. With `sleep_state_i` = 0, no wake status is set.
- R10: A read request returns `rd_vld_o` = 1 and, on the next cycle, the view {pending[11], pin level[10], wake status[9], interrupt status[8], control[7:0]} of the selected pin.
- R11: Writes, triggers and status of one pin do not affect any other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl_i | input | PIN_COUNT | Filtered level of each pin |
| sleep_state_i | input | 2 | Current sleep state: 0 awake, 1 to 3 the sleep states |
| wr_en_i | input | 1 | Write strobe |
| wr_pin_i | input | PW | Pin addressed by the write |
| wr_data_i | input | 10 | Control bits [7:0] and clear bits [9:8] |
| rd_en_i | input | 1 | Read request |
| rd_pin_i | input | PW | Pin addressed by the read |
| rd_vld_o | output | 1 | Read data valid |
| rd_data_o | output | 12 | Read view of the addressed pin |
| pend_o | output | PIN_COUNT | Pending flag per pin |
| irq_o | output | 1 | OR of all pending flags, registered |

## Verification
The hardest situation to reach is a clear that lands while a level-mode trigger is still active, where the set must win over the clear. The stimulus holds the pin at its active level, issues the clear write and reads back at once. It then moves the pin away and clears again to show that the status drops. A second hard case is a status bit set while masked and then exposed by an unmask write alone. The bench reaches it by raising the pin with unmask at 0 and only later rewriting the control word with unmask set.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int CFG_W  = 8;
  localparam int WR_W   = 10;
  localparam int VIEW_W = 12;
  localparam int B_ISTS = 8;
  localparam int B_WSTS = 9;

  typedef enum logic [1:0] {
    POL_HIGH = 2'b00,
    POL_LOW  = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_e;

  typedef struct packed {
    logic [2:0] wake_en;
    logic       unmask;
    logic       irq_en;
    pol_e       pol;
    logic       lvl_mode;
  } cfg_t;
endpackage

// File: rtl/pin_lvl_track.sv
module pin_lvl_track #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign prev_o = sh_q[STAGES];
endmodule

// File: rtl/pin_trig_decode.sv
module pin_trig_decode
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl_mode_i,
  input  pol_e pol_i,
  input  logic lvl_i,
  input  logic prev_i,
  output logic hit_o
);
  logic rise, fall;

  assign rise = lvl_i & ~prev_i;
  assign fall = ~lvl_i & prev_i;

  always_comb begin
    hit_o = 1'b0;
    if (lvl_mode_i) begin
      unique case (pol_i)
        POL_HIGH: hit_o = lvl_i;
        POL_LOW:  hit_o = ~lvl_i;
        default:  hit_o = 1'b0;
      endcase
    end else begin
      unique case (pol_i)
        POL_HIGH: hit_o = rise;
        POL_LOW:  hit_o = fall;
        POL_BOTH: hit_o = rise | fall;
        default:  hit_o = 1'b0;
      endcase
    end
  end

  // R4: both-edges and reserved codes stay silent in level mode
  p_lvl_both_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (lvl_mode_i && pol_i[1]) |-> !hit_o);
  // R4: reserved code stays silent in edge mode
  p_edge_rsvd_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (!lvl_mode_i && pol_i == POL_RSVD) |-> !hit_o);
endmodule

// File: rtl/pin_stat_cell.sv
module pin_stat_cell
  import pin_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit_i,
  input  logic [1:0] sleep_i,
  input  logic       wr_hit_i,
  input  cfg_t       wr_cfg_i,
  input  logic [1:0] wr_clr_i,
  output cfg_t       cfg_o,
  output logic       ists_o,
  output logic       wsts_o,
  output logic       pend_o
);
  cfg_t cfg_q;
  logic ists_q, wsts_q, pend_q;
  logic ists_n, wsts_n, unm_n, wake_sel;
  logic [3:0] wk_ext;

  assign wk_ext   = {cfg_q.wake_en, 1'b0};
  assign wake_sel = wk_ext[sleep_i];

  always_comb begin
    ists_n = ists_q;
    if (hit_i && cfg_q.irq_en)        ists_n = 1'b1;
    else if (wr_hit_i && wr_clr_i[0]) ists_n = 1'b0;

    wsts_n = wsts_q;
    if (hit_i && wake_sel)            wsts_n = 1'b1;
    else if (wr_hit_i && wr_clr_i[1]) wsts_n = 1'b0;

    unm_n = wr_hit_i ? wr_cfg_i.unmask : cfg_q.unmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      ists_q <= 1'b0;
      wsts_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_hit_i) cfg_q <= wr_cfg_i;
      ists_q <= ists_n;
      wsts_q <= wsts_n;
      pend_q <= (ists_n | wsts_n) & unm_n;
    end
  end

  assign cfg_o  = cfg_q;
  assign ists_o = ists_q;
  assign wsts_o = wsts_q;
  assign pend_o = pend_q;

  // R5: disabled pin never gains interrupt status
  p_no_set_when_off_r5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.irq_en && !ists_q) |=> !ists_q);
  // R6: status holds until a clear arrives
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ists_q && !(wr_hit_i && wr_clr_i[0])) |=> ists_q);
  // R7: a clear without a concurrent trigger empties status
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_hit_i && wr_clr_i[0] && !(hit_i && cfg_q.irq_en)) |=> !ists_q);
  // R3: an active enabled trigger always leaves status set
  p_level_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.irq_en && hit_i) |=> ists_q);
  // R8: pending only with unmask and some status
  p_pend_gate_r8: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (cfg_q.unmask && (ists_q || wsts_q)));
  // R9: awake state never creates wake status
  p_awake_no_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (sleep_i == 2'd0 && !wsts_q) |=> !wsts_q);
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 4,
  parameter int SYNC_STAGES = 1,
  localparam int PW = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_COUNT-1:0] pin_lvl_i,
  input  logic [1:0]           sleep_state_i,
  input  logic                 wr_en_i,
  input  logic [PW-1:0]        wr_pin_i,
  input  logic [WR_W-1:0]      wr_data_i,
  input  logic                 rd_en_i,
  input  logic [PW-1:0]        rd_pin_i,
  output logic                 rd_vld_o,
  output logic [VIEW_W-1:0]    rd_data_o,
  output logic [PIN_COUNT-1:0] pend_o,
  output logic                 irq_o
);
  logic [VIEW_W-1:0] view [PIN_COUNT];
  logic [VIEW_W-1:0] rd_sel;
  logic              rd_vld_q, irq_q;
  logic [VIEW_W-1:0] rd_data_q;
  cfg_t              wr_cfg;

  assign wr_cfg = cfg_t'(wr_data_i[CFG_W-1:0]);

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
    logic lvl, prev, hit, ists, wsts;
    cfg_t cfg;

    pin_lvl_track #(.STAGES(SYNC_STAGES)) u_track (
      .clk(clk), .rst(rst), .pin_i(pin_lvl_i[g]),
      .lvl_o(lvl), .prev_o(prev)
    );

    pin_trig_decode u_dec (
      .clk(clk), .rst(rst), .lvl_mode_i(cfg.lvl_mode), .pol_i(cfg.pol),
      .lvl_i(lvl), .prev_i(prev), .hit_o(hit)
    );

    pin_stat_cell u_cell (
      .clk(clk), .rst(rst), .hit_i(hit), .sleep_i(sleep_state_i),
      .wr_hit_i(wr_en_i && (wr_pin_i == PW'(g))),
      .wr_cfg_i(wr_cfg), .wr_clr_i(wr_data_i[B_WSTS:B_ISTS]),
      .cfg_o(cfg), .ists_o(ists), .wsts_o(wsts), .pend_o(pend_o[g])
    );

    assign view[g] = {pend_o[g], lvl, wsts, ists, cfg};
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < PIN_COUNT; i++)
      if (rd_pin_i == PW'(i)) rd_sel = view[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      rd_vld_q <= rd_en_i;
      if (rd_en_i) rd_data_q <= rd_sel;
      irq_q <= |pend_o;
    end
  end

  assign rd_vld_o  = rd_vld_q;
  assign rd_data_o = rd_data_q;
  assign irq_o     = irq_q;

  // R10: every read request is answered on the next cycle
  p_rd_answer_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_vld_o);
  // R10: no valid without a request
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_vld_o);
  // R8: interrupt line idle when nothing is pending
  p_irq_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (pend_o == '0) |=> !irq_o);
endmodule

// File: tb/sim_pin_irq_detect.sv
module sim_pin_irq_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pins = '0;
  logic [1:0]  sleep = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_pin = '0;
  logic [9:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_pin = '0;
  logic        rd_vld;
  logic [11:0] rd_data;
  logic [3:0]  pend;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  pin_irq_detect u0 (
    .clk(clk), .rst(rst), .pin_lvl_i(pins), .sleep_state_i(sleep),
    .wr_en_i(wr_en), .wr_pin_i(wr_pin), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_pin_i(rd_pin), .rd_vld_o(rd_vld),
    .rd_data_o(rd_data), .pend_o(pend), .irq_o(irq)
  );

  function automatic logic [7:0] cw(input logic md, input logic [1:0] pol,
                                    input logic en, input logic unm,
                                    input logic [2:0] wk);
    return {wk, unm, en, pol, md};
  endfunction

  function automatic logic [11:0] vw(input logic [7:0] c, input logic is,
                                     input logic ws, input logic lv,
                                     input logic pd);
    return {pd, lv, ws, is, c};
  endfunction

  // monitor: pops expected read views and compares
  always @(negedge clk) begin
    if (rd_vld) begin
      logic [11:0] e;
      string t;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected read data actual=%h expected=none", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] p, input logic [9:0] d);
    wr_en = 1'b1; wr_pin = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] p, input logic [11:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; rd_pin = p;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    n_chk++;
    if (rd_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 valid lingered actual=%b expected=0", rd_vld);
    end
  endtask

  task automatic chk_bit(input logic a, input logic e, input string t);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", t, a, e);
    end
  endtask

  task automatic set_pin(input int p, input logic v);
    pins[p] = v;
    settle(3);
  endtask

  initial begin
    logic [7:0] c;
    settle(3);
    rst = 1'b0;
    settle(1);

    // R1 reset state
    rd_expect(0, 12'h000, "R1 pin0 after reset");
    rd_expect(3, 12'h000, "R1 pin3 after reset");
    chk_bit(irq, 1'b0, "R1 irq after reset");
    chk_bit(pend[0], 1'b0, "R1 pending after reset");

    // R2 rising edge
    c = cw(0, 2'b00, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 1);
    rd_expect(0, vw(c, 1, 0, 1, 1), "R2 rising edge sets status");
    chk_bit(irq, 1'b1, "R8 irq follows pending");
    wr(0, {2'b01, c});
    rd_expect(0, vw(c, 0, 0, 1, 0), "R7 clear rising status");
    set_pin(0, 0);
    rd_expect(0, vw(c, 0, 0, 0, 0), "R2 falling edge ignored in rising mode");

    // R2 falling edge
    c = cw(0, 2'b01, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 1);
    rd_expect(0, vw(c, 0, 0, 1, 0), "R2 rise ignored in falling mode");
    set_pin(0, 0);
    rd_expect(0, vw(c, 1, 0, 0, 1), "R2 falling edge sets status");
    wr(0, {2'b01, c});

    // R2 both edges
    c = cw(0, 2'b10, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 1);
    rd_expect(0, vw(c, 1, 0, 1, 1), "R2 both-edge mode on rise");
    wr(0, {2'b01, c});
    set_pin(0, 0);
    rd_expect(0, vw(c, 1, 0, 0, 1), "R2 both-edge mode on fall");
    wr(0, {2'b01, c});

    // R6 merged edges
    c = cw(0, 2'b00, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 1);
    set_pin(0, 0);
    set_pin(0, 1);
    rd_expect(0, vw(c, 1, 0, 1, 1), "R6 repeated edges keep status");
    wr(0, {2'b01, c});
    rd_expect(0, vw(c, 0, 0, 1, 0), "R6 single clear removes merged edges");
    set_pin(0, 0);

    // R3 level high
    c = cw(1, 2'b00, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 1);
    rd_expect(0, vw(c, 1, 0, 1, 1), "R3 level high sets status");
    wr(0, {2'b01, c});
    rd_expect(0, vw(c, 1, 0, 1, 1), "R3 clear loses to active level");
    set_pin(0, 0);
    rd_expect(0, vw(c, 1, 0, 0, 1), "R3 status held after level leaves");
    wr(0, {2'b01, c});
    rd_expect(0, vw(c, 0, 0, 0, 0), "R3 clear after level leaves");

    // R3 level low (pin currently low)
    c = cw(1, 2'b01, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    settle(2);
    rd_expect(0, vw(c, 1, 0, 0, 1), "R3 level low sets status");
    wr(0, {2'b01, c});
    rd_expect(0, vw(c, 1, 0, 0, 1), "R3 clear loses to active low");
    set_pin(0, 1);
    wr(0, {2'b01, c});
    rd_expect(0, vw(c, 0, 0, 1, 0), "R3 low-level status cleared");

    // R4 silent codes
    c = cw(1, 2'b10, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 0);
    set_pin(0, 1);
    rd_expect(0, vw(c, 0, 0, 1, 0), "R4 level mode code 10 silent");
    c = cw(1, 2'b11, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 0);
    rd_expect(0, vw(c, 0, 0, 0, 0), "R4 level mode code 11 silent");
    c = cw(0, 2'b11, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 1);
    set_pin(0, 0);
    rd_expect(0, vw(c, 0, 0, 0, 0), "R4 edge mode code 11 silent");

    // R5 enable off
    c = cw(0, 2'b00, 0, 1, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 1);
    rd_expect(0, vw(c, 0, 0, 1, 0), "R5 disabled edge sets nothing");
    c = cw(0, 2'b00, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    settle(2);
    rd_expect(0, vw(c, 0, 0, 1, 0), "R5 late enable not retroactive");
    set_pin(0, 0);

    // R8 mask, R7 write-back
    c = cw(0, 2'b00, 1, 0, 3'b000);
    wr(0, {2'b00, c});
    set_pin(0, 1);
    rd_expect(0, vw(c, 1, 0, 1, 0), "R8 masked status not pending");
    chk_bit(irq, 1'b0, "R8 masked pin keeps irq low");
    c = cw(0, 2'b00, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    chk_bit(pend[0], 1'b1, "R8 unmask exposes pending at once");
    settle(1);
    chk_bit(irq, 1'b1, "R8 irq one cycle after pending");
    rd_expect(0, vw(c, 1, 0, 1, 1), "R8 unmasked view");
    wr(0, vw(c, 1, 0, 1, 1) & 12'h3ff);
    rd_expect(0, vw(c, 0, 0, 1, 0), "R7 write-back clears and keeps config");
    set_pin(0, 0);

    // R9 wake
    sleep = 2'd2;
    c = cw(0, 2'b00, 0, 1, 3'b010);
    wr(0, {2'b00, c});
    set_pin(0, 1);
    rd_expect(0, vw(c, 0, 1, 1, 1), "R9 wake in state 2 without irq enable");
    wr(0, {2'b00, c});
    rd_expect(0, vw(c, 0, 1, 1, 1), "R7 zero clear bits keep wake status");
    wr(0, {2'b10, c});
    rd_expect(0, vw(c, 0, 0, 1, 0), "R7 wake status cleared");
    sleep = 2'd1;
    set_pin(0, 0);
    set_pin(0, 1);
    rd_expect(0, vw(c, 0, 0, 1, 0), "R9 state 1 does not use enable bit 6");
    sleep = 2'd0;
    c = cw(0, 2'b00, 0, 1, 3'b111);
    wr(0, {2'b00, c});
    set_pin(0, 0);
    set_pin(0, 1);
    rd_expect(0, vw(c, 0, 0, 1, 0), "R9 awake state sets no wake");
    sleep = 2'd3;
    c = cw(0, 2'b00, 0, 1, 3'b100);
    wr(0, {2'b00, c});
    set_pin(0, 0);
    set_pin(0, 1);
    rd_expect(0, vw(c, 0, 1, 1, 1), "R9 wake in state 3");
    wr(0, {2'b10, c});
    sleep = 2'd0;
    set_pin(0, 0);

    // R11 isolation
    c = cw(0, 2'b00, 1, 1, 3'b000);
    wr(0, {2'b00, c});
    wr(1, {2'b00, c});
    set_pin(1, 1);
    rd_expect(1, vw(c, 1, 0, 1, 1), "R11 pin1 triggers");
    rd_expect(0, vw(c, 0, 0, 0, 0), "R11 pin0 untouched by pin1");
    wr(2, {2'b11, cw(1, 2'b01, 1, 0, 3'b111)});
    rd_expect(1, vw(c, 1, 0, 1, 1), "R11 write to pin2 leaves pin1");
    chk_bit(pend[0], 1'b0, "R11 pin0 pending stays low");

    settle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule